// File: doc/BRIEF.md
# Two-Wire Page Write Slave

This block is the receive side of a two-wire serial interface that sits in front of a small nonvolatile byte memory. It samples the clock and data lines and recognises bus start and stop conditions. It then accepts a device-select byte, one memory address byte and a run of data bytes. Each accepted byte is acknowledged by pulling the data line low through an open-drain enable. The data bytes are collected in a 16-entry page buffer. The page is the 16-byte region that the upper four address bits select, and the byte offset wraps inside that page.

A stop condition that follows at least one data byte commits the buffer. A modelled internal write cycle then runs for a parameterised number of system clocks. During that cycle the buffered bytes are presented on a simple memory write port, one per clock, and the busy output stays high. The slave ignores the bus until the cycle ends.

Top module: `page_wr_slave`

## Requirements
- R1: After reset, `sda_oe_o`, `busy_o` and `mem_we_o` are all low.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Bits are shifted in MSB first on SCL rising edges. An acknowledge drives `sda_oe_o` high from the SCL fall after the eighth bit to the SCL fall after the ninth bit.
- R3: The device-select byte is accepted only if bits [7:4] equal 1010, bits [3:1] equal the `DEV_SEL` parameter and bit 0 is 0 (write). Any other value is not acknowledged. In that case no later byte is acknowledged and nothing is stored until the next start.
- R4: After an accepted device-select byte, the address byte and every data byte are acknowledged.
- R5: A transaction with one data byte stores that byte at the given address.
- R6: Successive data bytes go to successive offsets. Address bits [7:4] stay fixed, and the offset in bits [3:0] wraps from 15 to 0.
- R7: When more than 16 data bytes are sent, a later byte overwrites the earlier byte at the same offset.
- R8: A stop after at least one acknowledged data byte raises `busy_o` for exactly `WR_CYCLES` clocks. During that time only the loaded offsets appear on the memory port, and `mem_we_o` is never high outside busy.
- R9: A stop before any data byte starts no write cycle and stores nothing.
- R10: While `busy_o` is high, the slave acknowledges nothing and ignores any start. A transaction sent during busy stores nothing.
- R11: Bytes at offsets that were not loaded keep their previous memory contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low (acknowledge) |
| busy_o | output | 1 | High for the duration of the internal write cycle |
| mem_we_o | output | 1 | Write strobe to the memory array |
| mem_addr_o | output | 8 | Memory byte address for the strobe |
| mem_data_o | output | 8 | Memory byte data for the strobe |

## Verification
The hardest state to reach is a complete, well-formed transaction that arrives while a write cycle is already running. Such a transaction must produce no acknowledge, must not disturb the pending commit, and must leave the slave ready for the next start once busy drops. The bench reaches it by issuing a new start directly after the stop of a byte write. It overrides `WR_CYCLES` so that the cycle outlasts a four-byte transfer. It then checks the acknowledge count, the busy duration and the full memory image. A normal write right after checks that the slave recovers. Wrapping and overwrite are reached with a 12-byte transfer that starts near the end of a page and a 20-byte transfer.

// File: rtl/page_wr_pkg.sv
package page_wr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADDR,
        ST_DATA,
        ST_SKIP,
        ST_BUSY
    } slv_state_e;
endpackage

// File: rtl/pw_line_cond.sv
module pw_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sync;
        logic [STAGES-1:0] sda_sync;
        logic              scl_prev;
        logic              sda_prev;
    } cond_t;

    cond_t c_d, c_q;

    always_comb begin
        c_d          = c_q;
        c_d.scl_sync = {c_q.scl_sync[STAGES-2:0], scl_i};
        c_d.sda_sync = {c_q.sda_sync[STAGES-2:0], sda_i};
        c_d.scl_prev = c_q.scl_sync[STAGES-1];
        c_d.sda_prev = c_q.sda_sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign scl_o      = c_q.scl_sync[STAGES-1];
    assign sda_o      = c_q.sda_sync[STAGES-1];
    assign scl_rise_o = scl_o && !c_q.scl_prev;
    assign scl_fall_o = !scl_o && c_q.scl_prev;
    assign start_o    = scl_o && c_q.scl_prev && c_q.sda_prev && !sda_o;
    assign stop_o     = scl_o && c_q.scl_prev && !c_q.sda_prev && sda_o;

    // R2
    start_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(scl_o));
endmodule

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [PAGE_W-1:0] wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PAGE_W-1:0] rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o
);
    localparam int DEPTH = 1 << PAGE_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0]             vld;
    } pbuf_t;

    pbuf_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (clr_i) begin
                b_d.vld[i] = 1'b0;
            end else if (wr_i && (wr_idx_i == PAGE_W'(i))) begin
                b_d.data[i] = wr_data_i;
                b_d.vld[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_data_o = b_q.data[rd_idx_i];
    assign rd_vld_o  = b_q.vld[rd_idx_i];

    // R6
    slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> b_q.vld[$past(wr_idx_i)]);
endmodule

// File: rtl/pw_wr_timer.sv
module pw_wr_timer #(
    parameter int WR_CYCLES = 50000,
    parameter int PAGE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    output logic              busy_o,
    output logic              stream_o,
    output logic [PAGE_W-1:0] idx_o,
    output logic              done_o
);
    localparam int DEPTH = 1 << PAGE_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    if (WR_CYCLES < DEPTH + 1) begin : g_len_check
        $error("WR_CYCLES must exceed the page depth");
    end

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!t_q.busy) begin
            if (launch_i) begin
                t_d.busy = 1'b1;
                t_d.cnt  = '0;
            end
        end else if (done_o) begin
            t_d.busy = 1'b0;
            t_d.cnt  = '0;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy_o   = t_q.busy;
    assign done_o   = t_q.busy && (t_q.cnt == CNT_W'(WR_CYCLES - 1));
    assign stream_o = t_q.busy && (t_q.cnt < CNT_W'(DEPTH));
    assign idx_o    = t_q.cnt[PAGE_W-1:0];

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/page_wr_slave.sv
module page_wr_slave
    import page_wr_pkg::*;
#(
    parameter int         WR_CYCLES = 50000,
    parameter logic [2:0] DEV_SEL   = 3'b000,
    parameter int         SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [BYTE_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_data_o
);
    localparam int PAGE_W = 4;
    localparam int BASE_W = BYTE_W - PAGE_W;
    localparam int NBIT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        slv_state_e        st;
        logic [BYTE_W-1:0] sh;
        logic [NBIT_W-1:0] nbit;
        logic              ack_ph;
        logic              oe;
        logic [BASE_W-1:0] base;
        logic [PAGE_W-1:0] ptr;
        logic              have;
    } ctl_t;

    ctl_t r_d, r_q;

    logic scl_w, sda_w, scl_rise_w, scl_fall_w, start_w, stop_w;
    logic buf_clr, buf_wr, launch, tmr_busy, stream, done;
    logic [PAGE_W-1:0] s_idx;
    logic [BYTE_W-1:0] rd_data;
    logic              rd_vld;
    logic              dev_hit;

    pw_line_cond #(.STAGES(SYNC_STG)) cond_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_w),
        .sda_o      (sda_w),
        .scl_rise_o (scl_rise_w),
        .scl_fall_o (scl_fall_w),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    pw_page_buf #(.PAGE_W(PAGE_W), .DATA_W(BYTE_W)) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .wr_i      (buf_wr),
        .wr_idx_i  (r_q.ptr),
        .wr_data_i (r_q.sh),
        .rd_idx_i  (s_idx),
        .rd_data_o (rd_data),
        .rd_vld_o  (rd_vld)
    );

    pw_wr_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .busy_o   (tmr_busy),
        .stream_o (stream),
        .idx_o    (s_idx),
        .done_o   (done)
    );

    assign dev_hit = (r_q.sh[7:4] == 4'b1010) && (r_q.sh[3:1] == DEV_SEL) && !r_q.sh[0];

    always_comb begin
        r_d     = r_q;
        buf_clr = 1'b0;
        buf_wr  = 1'b0;
        launch  = 1'b0;
        if (r_q.st == ST_BUSY) begin
            if (done) begin
                r_d.st   = ST_IDLE;
                r_d.have = 1'b0;
                buf_clr  = 1'b1;
            end
        end else if (start_w) begin
            r_d.st     = ST_DEV;
            r_d.nbit   = '0;
            r_d.ack_ph = 1'b0;
            r_d.oe     = 1'b0;
            r_d.have   = 1'b0;
            buf_clr    = 1'b1;
        end else if (stop_w) begin
            r_d.ack_ph = 1'b0;
            r_d.oe     = 1'b0;
            if (r_q.st == ST_DATA && r_q.have) begin
                r_d.st = ST_BUSY;
                launch = 1'b1;
            end else begin
                r_d.st   = ST_IDLE;
                r_d.have = 1'b0;
                buf_clr  = 1'b1;
            end
        end else if (r_q.st == ST_DEV || r_q.st == ST_ADDR || r_q.st == ST_DATA) begin
            if (scl_rise_w && !r_q.ack_ph && (r_q.nbit < NBIT_W'(BYTE_W))) begin
                r_d.sh   = {r_q.sh[BYTE_W-2:0], sda_w};
                r_d.nbit = r_q.nbit + 1'b1;
            end
            if (scl_fall_w) begin
                if (r_q.ack_ph) begin
                    r_d.ack_ph = 1'b0;
                    r_d.oe     = 1'b0;
                    r_d.nbit   = '0;
                end else if (r_q.nbit == NBIT_W'(BYTE_W)) begin
                    r_d.ack_ph = 1'b1;
                    r_d.oe     = 1'b1;
                    unique case (r_q.st)
                        ST_DEV: begin
                            if (dev_hit) begin
                                r_d.st = ST_ADDR;
                            end else begin
                                r_d.st     = ST_SKIP;
                                r_d.ack_ph = 1'b0;
                                r_d.oe     = 1'b0;
                            end
                        end
                        ST_ADDR: begin
                            r_d.base = r_q.sh[BYTE_W-1:PAGE_W];
                            r_d.ptr  = r_q.sh[PAGE_W-1:0];
                            r_d.st   = ST_DATA;
                        end
                        default: begin
                            buf_wr   = 1'b1;
                            r_d.ptr  = r_q.ptr + 1'b1;
                            r_d.have = 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o   = r_q.oe;
    assign busy_o     = tmr_busy;
    assign mem_we_o   = stream && rd_vld;
    assign mem_addr_o = {r_q.base, s_idx};
    assign mem_data_o = rd_data;

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o);

    // R8
    we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    // R8
    launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(stop_w) && $past(r_q.have)));

    // R3
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SKIP) |-> !sda_oe_o);

    // R2
    ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(scl_fall_w));
endmodule

// File: tb/page_wr_slave_tb.sv
module page_wr_slave_tb_top;
    localparam int WR = 2000;
    localparam int Q  = 10;

    typedef struct packed {
        logic [7:0] dev;
        logic [7:0] addr;
        logic [7:0] n;
        logic [7:0] seed;
        logic [7:0] acks;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'hA0, 8'h23, 8'd1,  8'h11, 8'd3},   // R5 single byte
        '{8'hA0, 8'h40, 8'd4,  8'h50, 8'd6},   // R6 short page
        '{8'hA0, 8'h7B, 8'd12, 8'h80, 8'd14},  // R6 offset wrap
        '{8'hA1, 8'h30, 8'd2,  8'h22, 8'd0},   // R3 read bit set
        '{8'hB0, 8'h30, 8'd2,  8'h33, 8'd0},   // R3 wrong type nibble
        '{8'hA2, 8'h30, 8'd2,  8'h44, 8'd0},   // R3 select bits differ
        '{8'hA0, 8'h95, 8'd20, 8'hC0, 8'd22},  // R7 overwrite
        '{8'hA0, 8'hE0, 8'd0,  8'h00, 8'd2}    // R9 address only
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_line;
    logic sda_oe, busy, mem_we;
    logic [7:0] mem_addr, mem_data;

    int runs = 0;
    int fails = 0;
    int busy_total = 0;
    bit finished = 1'b0;
    logic [7:0] obs_mem [256];
    logic [7:0] exp_mem [256];

    always #5 clk = ~clk;

    assign sda_line = sda_oe ? 1'b0 : sda_drv;

    page_wr_slave #(.WR_CYCLES(WR), .DEV_SEL(3'b000)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .busy_o     (busy),
        .mem_we_o   (mem_we),
        .mem_addr_o (mem_addr),
        .mem_data_o (mem_data)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) obs_mem[i] <= 8'h00;
        end else begin
            if (mem_we) obs_mem[mem_addr] <= mem_data;
            if (busy) busy_total <= busy_total + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; scl = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_drv = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; tick(Q);
            scl = 1'b1; tick(Q);
            scl = 1'b0; tick(Q);
        end
        sda_drv = 1'b1; tick(Q);
        scl = 1'b1; tick(Q / 2);
        acked = sda_oe;
        tick(Q - Q / 2);
        scl = 1'b0; tick(Q);
    endtask

    task automatic xfer(input logic [7:0] dev, input logic [7:0] addr, input int n,
                        input logic [7:0] seed, output int acks);
        bit a;
        acks = 0;
        bus_start();
        send_byte(dev, a);  acks += int'(a);
        send_byte(addr, a); acks += int'(a);
        for (int i = 0; i < n; i++) begin
            send_byte(seed + 8'(i), a);
            acks += int'(a);
        end
        bus_stop();
    endtask

    task automatic model(input logic [7:0] addr, input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            exp_mem[{addr[7:4], 4'(addr[3:0] + 4'(i))}] = seed + 8'(i);
        end
    endtask

    task automatic wait_idle();
        for (int k = 0; k < WR + 50 && busy; k++) tick(1);
        tick(4);
    endtask

    task automatic check_image(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 256; i++) begin
            if (obs_mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, int'(obs_mem[first]), int'(exp_mem[first]));
    endtask

    initial begin
        int acks;
        int b0;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        tick(3);
        // R1 reset state
        check(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(mem_we == 1'b0, "R1 mem_we", int'(mem_we), 0);
        rst_n = 1'b1;
        tick(5);

        for (int v = 0; v < 8; v++) begin
            int expb;
            b0 = busy_total;
            xfer(VECS[v].dev, VECS[v].addr, int'(VECS[v].n), VECS[v].seed, acks);
            if (VECS[v].acks != 0) model(VECS[v].addr, int'(VECS[v].n), VECS[v].seed);
            wait_idle();
            expb = (VECS[v].acks != 0 && VECS[v].n != 0) ? WR : 0;
            // R2 R3 R4 acknowledge count
            check(acks == int'(VECS[v].acks), "R4/R3 ack count", acks, int'(VECS[v].acks));
            // R8 R9 busy span
            check(busy_total - b0 == expb, "R8/R9 busy span", busy_total - b0, expb);
            // R5 R6 R7 R11 memory image, MSB first order
            check_image("R5/R6/R7/R11 memory image");
        end

        // R10 transaction during the write cycle
        b0 = busy_total;
        xfer(8'hA0, 8'h05, 1, 8'h6D, acks);
        model(8'h05, 1, 8'h6D);
        xfer(8'hA0, 8'h10, 2, 8'h77, acks);
        check(acks == 0, "R10 acks while busy", acks, 0);
        check(busy == 1'b1, "R10 still busy", int'(busy), 1);
        wait_idle();
        check(busy_total - b0 == WR, "R10 single busy span", busy_total - b0, WR);
        check_image("R10 memory image");

        // R10 recovery after the write cycle
        xfer(8'hA0, 8'hC8, 2, 8'h3C, acks);
        model(8'hC8, 2, 8'h3C);
        wait_idle();
        check(acks == 4, "R10 recovery acks", acks, 4);
        check_image("R10 recovery image");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            runs++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end
endmodule